// File: doc/BRIEF.md
# System Sleep State Controller

This block holds the global power state of a system and its sleep depth, following the common working / sleeping / soft-off / mechanical-off model. Software first writes a sleep depth into a held type field. The depth takes effect only when a separate go strobe rises. A power-button override, wake events and power failure act on the state machine directly. An operating-mode bit selects between legacy operation and managed operation. In legacy operation, software sleep requests are not honoured. While the system is working, the block also keeps a small processor idle-depth field.

The state machine has seven named states:
- OFF_MECH (G3)
- RUN (G0/S0)
- SLP1 to SLP4 (G1/S1 to G1/S4)
- OFF_SOFT (G2/S5)

Its named transitions are:
- boot: OFF_MECH to RUN
- sleep: RUN to SLPn
- soft-off: RUN to OFF_SOFT
- override: RUN or SLPn to OFF_SOFT
- wake: SLPn or OFF_SOFT to RUN
- power-fail: any state to OFF_MECH

Top module: `pwr_state_ctl`

## Requirements
- R1: After reset the outputs are gstate=3 (G3), sstate=5, sci_on=0, cstate=0 and slp_err=0.
- R2: In G3, boot_req moves the block to gstate=0, sstate=0 one cycle later. sci_on then equals boot_acpi.
- R3: In G0 with sci_on=1, a rising edge of slp_go acts on the effective type. Types 1 to 4 give gstate=1 with sstate equal to the type. Type 5 gives gstate=2, sstate=5. The effective type is slp_type_in when slp_type_wr is high in the same cycle, and the held type otherwise.
- R4: With sci_on=0, slp_type_wr does not change the held type, and slp_go does not change the state.
- R5: Type codes 0, 6 and 7 applied with a go edge in G0 with sci_on=1 leave the state unchanged. slp_err is high for exactly the next cycle.
- R6: slp_go acts only on its rising edge. Holding it high does not cause a second transition.
- R7: pwrbtn_ovr in G0 or G1 moves the block to gstate=2, sstate=5. In G0 it has priority over a go edge.
- R8: wake_evt in G1 or G2 moves the block to gstate=0, sstate=0. wake_evt has no effect in G0 or G3.
- R9: pwr_fail moves the block from any state to gstate=3, sstate=5 with sci_on=0. It has priority over every other input.
- R10: In G0, mode_on sets sci_on and mode_off clears it, with mode_off winning if both are high. Outside G0 both commands are ignored.
- R11: While the block stays in G0, cstate equals cst_req of the previous cycle. In every other state, and in the first cycle back in G0, cstate is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_req | input | 1 | Start-up request from mechanical off |
| boot_acpi | input | 1 | Mode selected at start-up (1 = managed) |
| mode_on | input | 1 | Command: enter managed mode |
| mode_off | input | 1 | Command: enter legacy mode |
| slp_type_wr | input | 1 | Write strobe for the sleep type field |
| slp_type_in | input | 3 | Sleep type value (1-4 sleep, 5 soft off) |
| slp_go | input | 1 | Sleep go strobe, edge-qualified |
| pwrbtn_ovr | input | 1 | Power-button override |
| wake_evt | input | 1 | Wake event |
| pwr_fail | input | 1 | Power failure |
| cst_req | input | 2 | Requested processor idle depth |
| gstate | output | 2 | Global state 0..3 |
| sstate | output | 3 | Sleep substate 0..5 |
| sci_on | output | 1 | Managed-mode enable status |
| cstate | output | 2 | Current processor idle depth |
| slp_err | output | 1 | One-cycle pulse on a rejected sleep type |

## Verification
Every state is registered, so a wrong internal state appears on gstate and sstate on the edge after the stimulus. A type held wrongly stays hidden until the next go edge, so the bench latches a value, then tries to overwrite it in legacy mode and then fires. A lost or sticky mode bit shows on sci_on at once. The bench also brings it out later by checking whether a sleep request is honoured.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

    typedef enum logic [2:0] {
        ST_OFF_MECH = 3'd0,
        ST_RUN      = 3'd1,
        ST_SLP1     = 3'd2,
        ST_SLP2     = 3'd3,
        ST_SLP3     = 3'd4,
        ST_SLP4     = 3'd5,
        ST_OFF_SOFT = 3'd6
    } sys_st_e;

    localparam logic [1:0] GS_WORK  = 2'd0;
    localparam logic [1:0] GS_SLEEP = 2'd1;
    localparam logic [1:0] GS_SOFT  = 2'd2;
    localparam logic [1:0] GS_MECH  = 2'd3;

    function automatic logic type_ok(input logic [2:0] t);
        return (t >= 3'd1) && (t <= 3'd5);
    endfunction

    function automatic sys_st_e type_target(input logic [2:0] t);
        sys_st_e r;
        case (t)
            3'd1:    r = ST_SLP1;
            3'd2:    r = ST_SLP2;
            3'd3:    r = ST_SLP3;
            3'd4:    r = ST_SLP4;
            3'd5:    r = ST_OFF_SOFT;
            default: r = ST_RUN;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/slp_type_reg.sv
module slp_type_reg #(
    parameter int TYPE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acpi_mode,
    input  logic              wr,
    input  logic [TYPE_W-1:0] type_in,
    input  logic              go,
    output logic              go_rise,
    output logic [TYPE_W-1:0] eff_type
);
    logic [TYPE_W-1:0] held_q;
    logic              go_q;
    logic              take;

    assign take = wr && acpi_mode;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
            go_q   <= 1'b0;
        end else begin
            go_q <= go;
            if (take)
                held_q <= type_in;
        end
    end

    assign eff_type = take ? type_in : held_q;
    assign go_rise  = go && !go_q;

    // R4: legacy mode leaves the held field untouched
    p_hold_in_legacy_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        !acpi_mode |=> $stable(held_q));

    // R6: a held strobe yields no second edge
    p_single_edge_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        go_rise |=> !go_rise);

endmodule

// File: rtl/cstate_track.sv
module cstate_track #(
    parameter int CST_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stay_run,
    input  logic [CST_W-1:0] req,
    output logic [CST_W-1:0] cst
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            cst <= '0;
        else if (stay_run)
            cst <= req;
        else
            cst <= '0;
    end

    // R11: a departure from the working state drops the idle depth
    p_cst_clear_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        !stay_run |=> cst == '0);

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwr_state_pkg::*;
#(
    parameter int TYPE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_req,
    input  logic              boot_acpi,
    input  logic              mode_on,
    input  logic              mode_off,
    input  logic              go_rise,
    input  logic [TYPE_W-1:0] eff_type,
    input  logic              pwrbtn_ovr,
    input  logic              wake_evt,
    input  logic              pwr_fail,
    output logic              stay_run,
    output logic              sci_q,
    output logic              err_q,
    output logic [1:0]        gstate,
    output logic [2:0]        sstate
);
    sys_st_e st_q, st_d;
    logic    sci_d;
    logic    fire_ok, fire_bad;
    logic    in_sleep;

    assign in_sleep = (st_q == ST_SLP1) || (st_q == ST_SLP2) ||
                      (st_q == ST_SLP3) || (st_q == ST_SLP4);
    assign fire_ok  = go_rise && sci_q && type_ok(eff_type[2:0]);
    assign fire_bad = go_rise && sci_q && !type_ok(eff_type[2:0]) &&
                      (st_q == ST_RUN) && !pwrbtn_ovr && !pwr_fail;

    // next-state process
    always_comb begin
        st_d = st_q;
        if (pwr_fail) begin
            st_d = ST_OFF_MECH;
        end else begin
            unique case (st_q)
                ST_OFF_MECH: if (boot_req) st_d = ST_RUN;
                ST_RUN: begin
                    if (pwrbtn_ovr)   st_d = ST_OFF_SOFT;
                    else if (fire_ok) st_d = type_target(eff_type[2:0]);
                end
                ST_SLP1, ST_SLP2, ST_SLP3, ST_SLP4: begin
                    if (pwrbtn_ovr)    st_d = ST_OFF_SOFT;
                    else if (wake_evt) st_d = ST_RUN;
                end
                ST_OFF_SOFT: if (wake_evt) st_d = ST_RUN;
                default: st_d = ST_OFF_MECH;
            endcase
        end
    end

    always_comb begin
        sci_d = sci_q;
        if (pwr_fail)
            sci_d = 1'b0;
        else if (st_q == ST_OFF_MECH && boot_req)
            sci_d = boot_acpi;
        else if (st_q == ST_RUN) begin
            if (mode_off)     sci_d = 1'b0;
            else if (mode_on) sci_d = 1'b1;
        end
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_OFF_MECH;
            sci_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            sci_q <= sci_d;
            err_q <= fire_bad;
        end
    end

    assign stay_run = (st_q == ST_RUN) && (st_d == ST_RUN);

    // output process
    always_comb begin
        unique case (st_q)
            ST_OFF_MECH: begin gstate = GS_MECH;  sstate = 3'd5; end
            ST_RUN:      begin gstate = GS_WORK;  sstate = 3'd0; end
            ST_SLP1:     begin gstate = GS_SLEEP; sstate = 3'd1; end
            ST_SLP2:     begin gstate = GS_SLEEP; sstate = 3'd2; end
            ST_SLP3:     begin gstate = GS_SLEEP; sstate = 3'd3; end
            ST_SLP4:     begin gstate = GS_SLEEP; sstate = 3'd4; end
            ST_OFF_SOFT: begin gstate = GS_SOFT;  sstate = 3'd5; end
            default:     begin gstate = GS_MECH;  sstate = 3'd5; end
        endcase
    end

    // R9: power failure always lands in mechanical off with legacy mode
    p_fail_off_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (gstate == GS_MECH) && !sci_q);

    // R4: no sleep request is honoured in legacy mode
    p_legacy_stay_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && !sci_q && !pwrbtn_ovr && !pwr_fail) |=> st_q == ST_RUN);

    // R8: wake from any sleep depth returns to working
    p_wake_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (in_sleep && wake_evt && !pwrbtn_ovr && !pwr_fail) |=> st_q == ST_RUN);

    // R5: a rejected type leaves the block working
    p_err_stay_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> st_q == ST_RUN);

    // R10: the mode bit only moves while working, at boot or on power failure
    p_mode_gate_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        (in_sleep || st_q == ST_OFF_SOFT) && !pwr_fail |=> $stable(sci_q));

endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
    import pwr_state_pkg::*;
#(
    parameter int TYPE_W = 3,
    parameter int CST_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_req,
    input  logic              boot_acpi,
    input  logic              mode_on,
    input  logic              mode_off,
    input  logic              slp_type_wr,
    input  logic [TYPE_W-1:0] slp_type_in,
    input  logic              slp_go,
    input  logic              pwrbtn_ovr,
    input  logic              wake_evt,
    input  logic              pwr_fail,
    input  logic [CST_W-1:0]  cst_req,
    output logic [1:0]        gstate,
    output logic [2:0]        sstate,
    output logic              sci_on,
    output logic [CST_W-1:0]  cstate,
    output logic              slp_err
);
    logic              go_rise;
    logic [TYPE_W-1:0] eff_type;
    logic              stay_run;

    slp_type_reg #(.TYPE_W(TYPE_W)) u_type (
        .clk       (clk),
        .rst_n     (rst_n),
        .acpi_mode (sci_on),
        .wr        (slp_type_wr),
        .type_in   (slp_type_in),
        .go        (slp_go),
        .go_rise   (go_rise),
        .eff_type  (eff_type)
    );

    pwr_fsm #(.TYPE_W(TYPE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_req   (boot_req),
        .boot_acpi  (boot_acpi),
        .mode_on    (mode_on),
        .mode_off   (mode_off),
        .go_rise    (go_rise),
        .eff_type   (eff_type),
        .pwrbtn_ovr (pwrbtn_ovr),
        .wake_evt   (wake_evt),
        .pwr_fail   (pwr_fail),
        .stay_run   (stay_run),
        .sci_q      (sci_on),
        .err_q      (slp_err),
        .gstate     (gstate),
        .sstate     (sstate)
    );

    cstate_track #(.CST_W(CST_W)) u_cst (
        .clk      (clk),
        .rst_n    (rst_n),
        .stay_run (stay_run),
        .req      (cst_req),
        .cst      (cstate)
    );

    // R7: override leaves working or sleeping for soft off
    p_override_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (pwrbtn_ovr && !pwr_fail && (gstate == 2'd0 || gstate == 2'd1))
        |=> gstate == 2'd2 && sstate == 3'd5);

endmodule

// File: tb/test_pwr_state_ctl.sv
module test_pwr_state_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       boot_req = 0, boot_acpi = 0, mode_on = 0, mode_off = 0;
    logic       slp_type_wr = 0, slp_go = 0, pwrbtn_ovr = 0, wake_evt = 0, pwr_fail = 0;
    logic [2:0] slp_type_in = 0;
    logic [1:0] cst_req = 0;
    logic [1:0] gstate;
    logic [2:0] sstate;
    logic       sci_on;
    logic [1:0] cstate;
    logic       slp_err;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    pwr_state_ctl i_pwr_state_ctl (
        .clk(clk), .rst_n(rst_n), .boot_req(boot_req), .boot_acpi(boot_acpi),
        .mode_on(mode_on), .mode_off(mode_off), .slp_type_wr(slp_type_wr),
        .slp_type_in(slp_type_in), .slp_go(slp_go), .pwrbtn_ovr(pwrbtn_ovr),
        .wake_evt(wake_evt), .pwr_fail(pwr_fail), .cst_req(cst_req),
        .gstate(gstate), .sstate(sstate), .sci_on(sci_on), .cstate(cstate),
        .slp_err(slp_err)
    );

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    task automatic chk_gs(input string req, input int g, input int s);
        chk(req, {gstate, sstate}, (g << 3) | s);
    endtask

    task automatic fail_pulse();
        pwr_fail = 1; tick(); pwr_fail = 0;
    endtask

    task automatic boot(input logic acpi);
        boot_req = 1; boot_acpi = acpi; tick(); boot_req = 0; boot_acpi = 0;
    endtask

    task automatic write_type(input int t);
        slp_type_in = 3'(t); slp_type_wr = 1; tick(); slp_type_wr = 0;
    endtask

    task automatic go_pulse();
        slp_go = 1; tick(); slp_go = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog got=hang exp=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        #0;
        // R1 reset state
        chk_gs("R1 state", 3, 5);
        chk("R1 sci", sci_on, 0);
        chk("R1 cst", cstate, 0);
        chk("R1 err", slp_err, 0);

        // R8: wake in G3 has no effect
        wake_evt = 1; tick(); wake_evt = 0;
        chk_gs("R8 wake in G3", 3, 5);

        // R2 boot both modes
        for (int m = 0; m < 2; m++) begin
            fail_pulse();
            boot(1'(m));
            chk_gs("R2 boot state", 0, 0);
            chk("R2 boot mode", sci_on, m);
        end

        // R3/R5 type sweep: written earlier, and written with the go edge
        for (int same = 0; same < 2; same++) begin
            for (int t = 0; t < 8; t++) begin
                int eg, es, ee;
                fail_pulse();
                boot(1);
                if (same == 0) begin
                    write_type(t);
                    go_pulse();
                end else begin
                    slp_type_in = 3'(t); slp_type_wr = 1; slp_go = 1;
                    tick();
                    slp_type_wr = 0; slp_go = 0;
                end
                eg = (t >= 1 && t <= 4) ? 1 : (t == 5 ? 2 : 0);
                es = (t >= 1 && t <= 5) ? t : 0;
                ee = (t == 0 || t >= 6) ? 1 : 0;
                chk_gs("R3 sleep target", eg, es);
                chk("R5 err pulse", slp_err, ee);
                tick();
                chk("R5 err clears", slp_err, 0);
            end
        end

        // R4: legacy ignores type writes and go
        fail_pulse(); boot(1);
        write_type(2);
        mode_off = 1; tick(); mode_off = 0;
        chk("R10 mode off", sci_on, 0);
        write_type(4);
        go_pulse();
        chk_gs("R4 legacy go ignored", 0, 0);
        mode_on = 1; tick(); mode_on = 0;
        chk("R10 mode on", sci_on, 1);
        go_pulse();
        chk_gs("R4 held type kept", 1, 2);

        // R10: commands ignored while sleeping
        mode_off = 1; tick(); mode_off = 0;
        chk("R10 ignored in G1", sci_on, 1);
        wake_evt = 1; tick(); wake_evt = 0;
        chk_gs("R8 wake G1", 0, 0);
        chk("R10 mode kept", sci_on, 1);
        mode_on = 1; mode_off = 1; tick(); mode_on = 0; mode_off = 0;
        chk("R10 off wins", sci_on, 0);

        // R6: held strobe acts once
        fail_pulse(); boot(1);
        write_type(3);
        slp_go = 1; tick();
        chk_gs("R6 first edge", 1, 3);
        wake_evt = 1; tick(); wake_evt = 0;
        chk_gs("R6 woke", 0, 0);
        tick(); tick();
        chk_gs("R6 no refire", 0, 0);
        slp_go = 0; tick();
        go_pulse();
        chk_gs("R6 new edge", 1, 3);

        // R7: override from G1 and from G0 (beats go)
        pwrbtn_ovr = 1; tick(); pwrbtn_ovr = 0;
        chk_gs("R7 from G1", 2, 5);
        wake_evt = 1; tick(); wake_evt = 0;
        chk_gs("R8 wake G2", 0, 0);
        wake_evt = 1; tick(); wake_evt = 0;
        chk_gs("R8 wake in G0", 0, 0);
        write_type(1);
        pwrbtn_ovr = 1; slp_go = 1; tick(); pwrbtn_ovr = 0; slp_go = 0;
        chk_gs("R7 over go", 2, 5);

        // R9: fail from each state and over boot/wake
        pwr_fail = 1; wake_evt = 1; tick(); pwr_fail = 0; wake_evt = 0;
        chk_gs("R9 from G2", 3, 5);
        chk("R9 sci", sci_on, 0);
        pwr_fail = 1; boot_req = 1; boot_acpi = 1; tick();
        pwr_fail = 0; boot_req = 0; boot_acpi = 0;
        chk_gs("R9 over boot", 3, 5);
        boot(1); write_type(4); go_pulse();
        fail_pulse();
        chk_gs("R9 from G1", 3, 5);
        boot(1); fail_pulse();
        chk_gs("R9 from G0", 3, 5);

        // R11: idle depth sweep
        boot(1);
        for (int c = 0; c < 4; c++) begin
            cst_req = 2'(c); tick();
            chk("R11 follow", cstate, c);
        end
        write_type(2); go_pulse();
        chk("R11 zero in G1", cstate, 0);
        cst_req = 3;
        wake_evt = 1; tick(); wake_evt = 0;
        chk("R11 first G0 cycle", cstate, 0);
        tick();
        chk("R11 after return", cstate, 3);
        cst_req = 0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule